// File: doc/BRIEF.md
# Cascaded Integrator-Comb Decimator for a One-Bit Stream

This block turns the single-bit output of a delta-sigma modulator, arriving at the fast sample rate, into multi-bit PCM words at a rate lower by the decimation ratio `DECIM`. It is built from `ORDER` accumulators that run on every accepted input sample, followed by `ORDER` differencing stages that run once per output word. Together they apply a moving sum of length `DECIM`, `ORDER` times over. The response has nulls at the output rate and at each of its multiples, so the modulator noise near those frequencies is removed before it can alias into the band of interest. For a modulator of loop order L, `ORDER` should be L+1.

Each input bit is mapped to +1 or -1 before it is summed. Every output word is the signed sum of `DECIM^ORDER` weighted samples. Read as a two's-complement fraction with `ORDER*log2(DECIM)` fractional bits, the word is the average of the input, scaled into [-1, +1]; that scaling is the power-of-two right shift, done by placing the binary point. All internal registers are `ORDER*log2(DECIM)+2` bits wide and are allowed to wrap. `DECIM` must be a power of two, and at least 2.

Top module: `cic_decimator`

## Requirements
- R1: While `rst` is high at a clock edge, every accumulator, difference register and the sample counter are cleared. After that edge `outValid` and `outSettling` are 0 and `dataOut` is 0.
- R2: An input bit of 1 is summed as +1 and an input bit of 0 as -1. A long alternating 1,0 stream therefore gives output words of 0.
- R3: `outValid` is high for exactly one cycle after each `DECIM`-th accepted sample counted since reset. It is visible in the cycle after the clock edge that accepted that sample, and it is never high at any other time.
- R4: A cycle with `inValid` low is ignored. Its `inBit` does not enter any sum, and the cycle does not advance the sample count.
- R5: Number the accepted samples x[0], x[1], ... from reset, with x[i] taken as 0 for i < 0. Let h be the `ORDER`-fold convolution of a length-`DECIM` run of ones. Then the word produced after sample t = m*DECIM-1 equals the sum over j of h[j]*x[t-ORDER-j].
- R6: A steady stream of ones settles to +`DECIM^ORDER`, and a steady stream of zeros settles to -`DECIM^ORDER`. No word ever lies outside that range.
- R7: `outSettling` is high together with `outValid` on the first `ORDER` words after reset, and it is low on every later word.
- R8: The output stays exact when the accumulators wrap modulo 2^(`ORDER*log2(DECIM)+2`) over long runs.
- R9: A reset in the middle of a stream restarts the sample count, the filter history and the settling flag from scratch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sample-rate clock |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Marks `inBit` as a sample to accept in this cycle |
| inBit | input | 1 | Modulator bit: 1 means +1, 0 means -1 |
| dataOut | output | ORDER*log2(DECIM)+2 | Signed output word, equal to the average times DECIM^ORDER |
| outValid | output | 1 | One-cycle strobe that marks a new `dataOut` |
| outSettling | output | 1 | High with `outValid` on the first ORDER words after reset |

## Verification
The bench feeds steady ones, steady zeros, alternating bits, and long random streams with idle gaps. It compares every word with a direct convolution of the accepted samples. A design with an extra or missing delay in the accumulator chain shifts which samples each word weighs, so the mismatch shows up at once on the random stream. Counting idle cycles as samples, or letting their bits leak into a sum, breaks both the strobe spacing and the word values. Sizing the registers too narrow makes the extreme ±DECIM^ORDER words wrap to the wrong sign. A reset placed mid-run catches a design that keeps stale difference registers or skips the settling flags the second time.

// File: rtl/cic_pkg.sv
package cic_pkg;
  // Strobes from the control unit to the datapath
  typedef struct packed {
    logic sampleEn;   // accept the current input bit
    logic dumpEn;     // decimation instant: run the differencing stages
    logic settling;   // the word being dumped is one of the first ORDER
  } cic_strobe_t;
endpackage

// File: rtl/cic_ctrl.sv
module cic_ctrl
  import cic_pkg::*;
#(
  parameter int DECIM = 8,
  parameter int ORDER = 3
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        inValid,
  output cic_strobe_t strobes,
  output logic        outValid,
  output logic        outSettling
);
  localparam int CNT_W = $clog2(DECIM);
  localparam int SET_W = $clog2(ORDER + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DECIM - 1);

  logic [CNT_W-1:0] sampleCnt;
  logic [SET_W-1:0] dumpCnt;

  always_comb begin
    strobes.sampleEn = inValid;
    strobes.dumpEn   = inValid && (sampleCnt == LAST);
    strobes.settling = (dumpCnt < SET_W'(ORDER));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sampleCnt   <= '0;
      dumpCnt     <= '0;
      outValid    <= 1'b0;
      outSettling <= 1'b0;
    end else begin
      outValid    <= strobes.dumpEn;
      outSettling <= strobes.dumpEn && strobes.settling;
      if (strobes.dumpEn) sampleCnt <= '0;
      else if (inValid)   sampleCnt <= sampleCnt + 1'b1;
      if (strobes.dumpEn && strobes.settling) dumpCnt <= dumpCnt + 1'b1;
    end
  end

  // R3: a word strobe lasts one cycle and always follows an accepted sample
  assert_single_strobe_R3: assert property (@(posedge clk) disable iff (rst)
    outValid |=> !outValid);
  assert_strobe_cause_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(outValid) |-> $past(inValid));
  // R4: idle cycles do not advance the count
  assert_idle_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> $stable(sampleCnt));
  // R7: settling is only flagged on a word, and once cleared it stays cleared
  assert_settle_with_word_R7: assert property (@(posedge clk) disable iff (rst)
    outSettling |-> outValid);
  assert_settle_done_R7: assert property (@(posedge clk) disable iff (rst)
    !strobes.settling |=> !strobes.settling);
  // R1: reset leaves the output strobes low
  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!outValid && !outSettling));
endmodule

// File: rtl/cic_datapath.sv
module cic_datapath
  import cic_pkg::*;
#(
  parameter int DECIM = 8,
  parameter int ORDER = 3
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  cic_strobe_t                          strobes,
  input  logic                                 inBit,
  output logic [ORDER*$clog2(DECIM)+1:0]       dataOut
);
  localparam int SHIFT = $clog2(DECIM);
  localparam int ACC_W = ORDER * SHIFT + 2;
  localparam logic signed [ACC_W-1:0] PEAK = ACC_W'(1) << (ORDER * SHIFT);

  logic signed [ACC_W-1:0] inWord;
  logic signed [ACC_W-1:0] integ [ORDER];
  logic signed [ACC_W-1:0] dly   [ORDER];
  logic signed [ACC_W-1:0] comb  [ORDER+1];

  // 1 -> +1, 0 -> -1 in two's complement
  assign inWord = {{(ACC_W-1){~inBit}}, 1'b1};

  // Accumulators: each stage adds the previous stage's registered value
  for (genvar k = 0; k < ORDER; k++) begin : g_integ
    always_ff @(posedge clk) begin
      if (rst)                   integ[k] <= '0;
      else if (strobes.sampleEn) integ[k] <= integ[k] + ((k == 0) ? inWord : integ[(k == 0) ? 0 : k-1]);
    end
  end

  // Differencing stages: combinational chain sampled at the decimation instant
  assign comb[0] = integ[ORDER-1];
  for (genvar k = 0; k < ORDER; k++) begin : g_comb
    assign comb[k+1] = comb[k] - dly[k];
    always_ff @(posedge clk) begin
      if (rst)                 dly[k] <= '0;
      else if (strobes.dumpEn) dly[k] <= comb[k];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                 dataOut <= '0;
    else if (strobes.dumpEn) dataOut <= comb[ORDER];
  end

  // R6: every word lies within +/- DECIM^ORDER
  assert_word_range_R6: assert property (@(posedge clk) disable iff (rst)
    strobes.dumpEn |=> ($signed(dataOut) <= PEAK && $signed(dataOut) >= -PEAK));
  // R4: accumulators hold on idle cycles
  assert_integ_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !strobes.sampleEn |=> $stable(integ[0]));
  // R1: reset clears the output word
  assert_reset_word_R1: assert property (@(posedge clk)
    rst |=> (dataOut == '0));
endmodule

// File: rtl/cic_decimator.sv
module cic_decimator
  import cic_pkg::*;
#(
  parameter int DECIM = 8,
  parameter int ORDER = 3
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           inValid,
  input  logic                           inBit,
  output logic [ORDER*$clog2(DECIM)+1:0] dataOut,
  output logic                           outValid,
  output logic                           outSettling
);
  cic_strobe_t strobes;

  cic_ctrl #(.DECIM(DECIM), .ORDER(ORDER)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .inValid    (inValid),
    .strobes    (strobes),
    .outValid   (outValid),
    .outSettling(outSettling)
  );

  cic_datapath #(.DECIM(DECIM), .ORDER(ORDER)) u_dp (
    .clk    (clk),
    .rst    (rst),
    .strobes(strobes),
    .inBit  (inBit),
    .dataOut(dataOut)
  );
endmodule

// File: tb/tb_cic_decimator.sv
`timescale 1ns/1ps
module tb_cic_decimator;
  localparam int N  = 8;
  localparam int K  = 3;
  localparam int W  = K * $clog2(N) + 2;
  localparam int HL = K * (N - 1) + 1;
  localparam int PEAK = N ** K;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic inValid = 1'b0;
  logic inBit = 1'b0;
  logic [W-1:0] dataOut;
  logic outValid, outSettling;

  int xs[$];
  int expVal[$];
  bit expSet[$];
  int h[HL];
  int total = 0, bad = 0, outNum = 0, lastOut = 0;

  always #2.5 clk = ~clk;

  cic_decimator #(.DECIM(N), .ORDER(K)) dut (
    .clk(clk), .rst(rst), .inValid(inValid), .inBit(inBit),
    .dataOut(dataOut), .outValid(outValid), .outSettling(outSettling)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Impulse response: K-fold convolution of a length-N run of ones
  task automatic buildH();
    int tmp[HL];
    foreach (h[i]) h[i] = 0;
    h[0] = 1;
    for (int s = 0; s < K; s++) begin
      foreach (tmp[i]) begin
        tmp[i] = 0;
        for (int d = 0; d < N; d++) if (i - d >= 0) tmp[i] += h[i - d];
      end
      foreach (h[i]) h[i] = tmp[i];
    end
  endtask

  // Driver: applies one cycle of input and pushes the expected word when due
  task automatic feed(input bit b, input bit v);
    int ts, e;
    @(negedge clk);
    inBit = b;
    inValid = v;
    if (v) begin
      xs.push_back(b ? 1 : -1);
      if (xs.size() % N == 0) begin
        ts = xs.size() - 1;
        e = 0;
        for (int j = 0; j < HL; j++) if (ts - K - j >= 0) e += h[j] * xs[ts - K - j];
        expVal.push_back(e);
        expSet.push_back(outNum < K);
        outNum++;
      end
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1;
    inValid = 1'b0;
    repeat (2) @(negedge clk);
    check(outValid == 1'b0, "R1 outValid", outValid, 0);
    check(outSettling == 1'b0, "R1 outSettling", outSettling, 0);
    check(dataOut == '0, "R1 dataOut", int'(dataOut), 0);
    xs.delete();
    expVal.delete();
    expSet.delete();
    outNum = 0;
    rst = 1'b0;
  endtask

  // Monitor: pops the scoreboard whenever the design presents a word
  always @(negedge clk) begin
    if (!rst && outValid) begin
      if (expVal.size() == 0) begin
        check(1'b0, "R3 unexpected word", 1, 0);
      end else begin
        int ev;
        bit es;
        ev = expVal.pop_front();
        es = expSet.pop_front();
        lastOut = int'($signed(dataOut));
        check(lastOut == ev, "R5 R8 word value", lastOut, ev);
        check(outSettling == es, "R7 settling flag", outSettling, es);
      end
    end
  end

  initial begin
    buildH();
    doReset();
    // R2, R6: steady ones settle to +PEAK
    for (int i = 0; i < 20 * N; i++) feed(1'b1, 1'b1);
    repeat (2) feed(1'b0, 1'b0);
    check(lastOut == PEAK, "R6 ones", lastOut, PEAK);
    // R6: steady zeros settle to -PEAK
    for (int i = 0; i < 20 * N; i++) feed(1'b0, 1'b1);
    repeat (2) feed(1'b1, 1'b0);
    check(lastOut == -PEAK, "R6 zeros", lastOut, -PEAK);
    // R2: alternating bits average to zero
    for (int i = 0; i < 20 * N; i++) feed(i[0] ? 1'b0 : 1'b1, 1'b1);
    repeat (2) feed(1'b0, 1'b0);
    check(lastOut == 0, "R2 alternating", lastOut, 0);
    // R4, R8: long random stream with idle gaps; idle bits are random
    for (int i = 0; i < 3000; i++) feed(1'($urandom), ($urandom % 4) != 0);
    // R9: reset in mid-stream, then restart
    for (int i = 0; i < 5; i++) feed(1'b1, 1'b1);
    doReset();
    for (int i = 0; i < 2000; i++) feed(($urandom % 8) != 0, ($urandom % 3) != 0);
    repeat (4) feed(1'b0, 1'b0);
    // R3: every due word appeared exactly once
    check(expVal.size() == 0, "R3 missing words", expVal.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule